// File: doc/BRIEF.md
# PTP Frame Timestamp Unit

This block sits on the byte-wide receive and transmit paths between an Ethernet PHY and MAC, on a GMII-style interface (one byte per clock with a data-valid strobe). Both directions pass through it unchanged. Each direction has its own watcher. It samples the free-running local time on the start-of-frame delimiter, before it knows whether the frame matters. As the header bytes go by, it decides whether the frame is a precision-time event message. If so, it keeps the sample. If not, it throws the sample away.

A frame qualifies when it is IPv4/UDP, sent to the PTP event port, with protocol version 2 and a message type of SYNC or DELAY_REQUEST. For each such frame the block stores one record in a small queue for that direction. The record holds the captured time, the message type and the 16-bit sequence identifier. Software reads a record from the head of the queue and removes it with a one-cycle pop. A not-empty flag shows when records are waiting. A sticky overflow flag shows that a record was lost because the queue was full.

Top module: `ptp_frame_stamper`

## Requirements
- R1: Data and valid on each direction reach the matching outputs in the same cycle, unchanged.
- R2: The stored time is the value of `timeNow` in the clock cycle in which the 0xD5 delimiter byte is present with valid high, when that byte follows only 0x55 preamble bytes since valid rose.
- R3: Counting body bytes from 0, starting with the first byte after the delimiter, a frame qualifies only if all of these hold: bytes 12–13 are 0x08,0x00; byte 14 is 0x45; byte 23 is 0x11; bytes 36–37 carry the event port (default 319, sent high byte first); the low nibble of byte 43 is 2.
- R4: The message type is the low nibble of body byte 42. Value 0 (SYNC) and value 1 (DELAY_REQUEST) produce a record. Any other value produces none. The record's type output carries the nibble.
- R5: The sequence identifier is body byte 72 (high) followed by byte 73 (low). A record becomes visible at the queue head once byte 73 has been taken.
- R6: If valid falls before body byte 73 has been taken, the frame produces no record, and the next frame is handled normally.
- R7: The receive and transmit sides record and queue independently. Traffic on one never changes the other's queue or flags.
- R8: Each direction has a 4-entry first-in first-out queue. `NotEmpty` is high while records are held. A pop advances the head. A pop on an empty queue has no effect.
- R9: A qualifying frame that arrives while the queue is full is dropped without changing the stored records. It sets that direction's overflow flag, which stays set until reset.
- R10: After reset both queues are empty and both overflow flags are low.
- R11: A frame whose first valid byte is neither 0x55 nor 0xD5 is ignored until valid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Free-running local time |
| rxDataIn | input | 8 | Receive byte from the PHY |
| rxValidIn | input | 1 | Receive data valid from the PHY |
| rxDataOut | output | 8 | Receive byte to the MAC |
| rxValidOut | output | 1 | Receive data valid to the MAC |
| txDataIn | input | 8 | Transmit byte from the MAC |
| txValidIn | input | 1 | Transmit data valid from the MAC |
| txDataOut | output | 8 | Transmit byte to the PHY |
| txValidOut | output | 1 | Transmit data valid to the PHY |
| rxPop | input | 1 | Remove the receive queue head |
| rxNotEmpty | output | 1 | Receive queue holds a record |
| rxStampTime | output | 64 | Receive head: captured time |
| rxSeqId | output | 16 | Receive head: sequence identifier |
| rxMsgType | output | 4 | Receive head: message type nibble |
| rxOverflow | output | 1 | Sticky receive record loss |
| txPop | input | 1 | Remove the transmit queue head |
| txNotEmpty | output | 1 | Transmit queue holds a record |
| txStampTime | output | 64 | Transmit head: captured time |
| txSeqId | output | 16 | Transmit head: sequence identifier |
| txMsgType | output | 4 | Transmit head: message type nibble |
| txOverflow | output | 1 | Sticky transmit record loss |

## Verification
The in-line assertions check the following on every cycle:
- a time capture happens only on a valid delimiter byte;
- a record push happens only while valid has been high for two cycles;
- the queue count falls by one on a pop without a push;
- a push always leaves the queue non-empty;
- a push into a full queue raises the overflow flag and leaves the head untouched;
- the overflow flag never clears by itself.

Some behaviour shows up only in the bench's frame scenarios:
- whether the captured time matches the delimiter cycle;
- whether each header field test rejects a mismatched frame;
- whether truncated frames and junk-led frames are discarded;
- whether the two directions stay apart when frames overlap in time.

// File: rtl/ptp_stamper_pkg.sv
package ptp_stamper_pkg;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [7:0]  ETH_TYPE_H = 8'h08;
  localparam logic [7:0]  ETH_TYPE_L = 8'h00;
  localparam logic [7:0]  IP_VER_IHL = 8'h45;
  localparam logic [7:0]  IP_PROTO   = 8'h11;
  localparam logic [3:0]  PTP_VER    = 4'd2;
  localparam logic [3:0]  MSG_SYNC   = 4'd0;
  localparam logic [3:0]  MSG_DREQ   = 4'd1;
  localparam int          SEQ_W      = 16;
  localparam int          TYPE_W     = 4;

  // strobes from the frame parser to the record datapath
  typedef struct packed {
    logic capture;     // sample the time on the delimiter
    logic latchType;   // keep the message type nibble
    logic latchSeqHi;  // keep the sequence high byte
    logic push;        // sequence low byte present: commit the record
  } stampStrb_t;

endpackage

// File: rtl/ptp_stamper_ctrl.sv
module ptp_stamper_ctrl
  import ptp_stamper_pkg::*;
#(
  parameter logic [15:0] PTP_PORT = 16'd319
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  output stampStrb_t strb
);

  localparam int OFS_SEQ_LO_I = 73;
  localparam int CNT_W        = $clog2(OFS_SEQ_LO_I + 1);

  localparam logic [CNT_W-1:0] OFS_ETH_H  = CNT_W'(12);
  localparam logic [CNT_W-1:0] OFS_ETH_L  = CNT_W'(13);
  localparam logic [CNT_W-1:0] OFS_IPVER  = CNT_W'(14);
  localparam logic [CNT_W-1:0] OFS_PROTO  = CNT_W'(23);
  localparam logic [CNT_W-1:0] OFS_PORT_H = CNT_W'(36);
  localparam logic [CNT_W-1:0] OFS_PORT_L = CNT_W'(37);
  localparam logic [CNT_W-1:0] OFS_MSG    = CNT_W'(42);
  localparam logic [CNT_W-1:0] OFS_VER    = CNT_W'(43);
  localparam logic [CNT_W-1:0] OFS_SEQ_HI = CNT_W'(72);
  localparam logic [CNT_W-1:0] OFS_SEQ_LO = CNT_W'(OFS_SEQ_LO_I);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DROP} parseState_t;

  parseState_t state, stateNxt;
  logic [CNT_W-1:0] byteCnt, byteCntNxt;
  logic matchOk;

  // field test for the byte at the current body offset
  always_comb begin
    matchOk = 1'b1;
    case (byteCnt)
      OFS_ETH_H:  matchOk = (inData == ETH_TYPE_H);
      OFS_ETH_L:  matchOk = (inData == ETH_TYPE_L);
      OFS_IPVER:  matchOk = (inData == IP_VER_IHL);
      OFS_PROTO:  matchOk = (inData == IP_PROTO);
      OFS_PORT_H: matchOk = (inData == PTP_PORT[15:8]);
      OFS_PORT_L: matchOk = (inData == PTP_PORT[7:0]);
      OFS_MSG:    matchOk = (inData[3:0] == MSG_SYNC) || (inData[3:0] == MSG_DREQ);
      OFS_VER:    matchOk = (inData[3:0] == PTP_VER);
      default:    matchOk = 1'b1;
    endcase
  end

  always_comb begin
    stateNxt   = state;
    byteCntNxt = byteCnt;
    strb       = '0;
    case (state)
      S_IDLE: begin
        if (inValid) begin
          if (inData == SFD_BYTE) begin
            strb.capture = 1'b1;
            byteCntNxt   = '0;
            stateNxt     = S_HDR;
          end else if (inData != PRE_BYTE) begin
            stateNxt = S_DROP;
          end
        end
      end
      S_HDR: begin
        if (!inValid) begin
          stateNxt = S_IDLE;
        end else if (!matchOk) begin
          stateNxt = S_DROP;
        end else begin
          strb.latchType  = (byteCnt == OFS_MSG);
          strb.latchSeqHi = (byteCnt == OFS_SEQ_HI);
          if (byteCnt == OFS_SEQ_LO) begin
            strb.push = 1'b1;
            stateNxt  = S_DROP;
          end
          byteCntNxt = byteCnt + 1'b1;
        end
      end
      default: begin
        if (!inValid) stateNxt = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteCnt <= '0;
    end else begin
      state   <= stateNxt;
      byteCnt <= byteCntNxt;
    end
  end

  // R2
  capture_on_sfd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (inValid && inData == SFD_BYTE));

  // R6
  push_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (inValid && $past(inValid)));

endmodule

// File: rtl/ptp_stamper_dp.sv
module ptp_stamper_dp
  import ptp_stamper_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stampStrb_t        strb,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [7:0]        inData,
  input  logic              pop,
  output logic              notEmpty,
  output logic [TIME_W-1:0] outTime,
  output logic [SEQ_W-1:0]  outSeq,
  output logic [TYPE_W-1:0] outType,
  output logic              overflow
);

  localparam int ENTRY_W = TIME_W + TYPE_W + SEQ_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W + 1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [TIME_W-1:0]  timeHold;
  logic [TYPE_W-1:0]  typeHold;
  logic [7:0]         seqHiHold;
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [PTR_W:0]     count;
  logic               full, doPush, doPop;
  logic [ENTRY_W-1:0] head;

  assign full   = (count == FULL_CNT);
  assign doPush = strb.push && !full;
  assign doPop  = pop && (count != '0);

  // speculative sample and header fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeHold  <= '0;
      typeHold  <= '0;
      seqHiHold <= '0;
    end else begin
      if (strb.capture)    timeHold  <= timeNow;
      if (strb.latchType)  typeHold  <= inData[TYPE_W-1:0];
      if (strb.latchSeqHi) seqHiHold <= inData;
    end
  end

  // one storage slot per queue entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PTR_W'(g))
        mem[g] <= {timeHold, typeHold, seqHiHold, inData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.push && full) overflow <= 1'b1;
    end
  end

  assign head     = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign outTime  = head[ENTRY_W-1 -: TIME_W];
  assign outType  = head[SEQ_W +: TYPE_W];
  assign outSeq   = head[SEQ_W-1:0];

  // R8
  pop_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && notEmpty && !strb.push) |=> (count == $past(count) - 1'b1));

  // R8
  push_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> notEmpty);

  // R9
  full_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full) |=> overflow);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full && !pop) |=> (full && $stable(outTime) && $stable(outSeq)));

endmodule

// File: rtl/ptp_frame_stamper.sv
module ptp_frame_stamper
  import ptp_stamper_pkg::*;
#(
  parameter int          TIME_W   = 64,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] PTP_PORT = 16'd319
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [7:0]        rxDataIn,
  input  logic              rxValidIn,
  output logic [7:0]        rxDataOut,
  output logic              rxValidOut,
  input  logic [7:0]        txDataIn,
  input  logic              txValidIn,
  output logic [7:0]        txDataOut,
  output logic              txValidOut,
  input  logic              rxPop,
  output logic              rxNotEmpty,
  output logic [TIME_W-1:0] rxStampTime,
  output logic [SEQ_W-1:0]  rxSeqId,
  output logic [TYPE_W-1:0] rxMsgType,
  output logic              rxOverflow,
  input  logic              txPop,
  output logic              txNotEmpty,
  output logic [TIME_W-1:0] txStampTime,
  output logic [SEQ_W-1:0]  txSeqId,
  output logic [TYPE_W-1:0] txMsgType,
  output logic              txOverflow
);

  localparam int LANES = 2;  // lane 0 receive, lane 1 transmit

  logic [7:0]        laneData  [LANES];
  logic              laneValid [LANES];
  logic              lanePop   [LANES];
  logic              laneNe    [LANES];
  logic [TIME_W-1:0] laneTime  [LANES];
  logic [SEQ_W-1:0]  laneSeq   [LANES];
  logic [TYPE_W-1:0] laneType  [LANES];
  logic              laneOvf   [LANES];

  assign laneData[0]  = rxDataIn;
  assign laneValid[0] = rxValidIn;
  assign lanePop[0]   = rxPop;
  assign laneData[1]  = txDataIn;
  assign laneValid[1] = txValidIn;
  assign lanePop[1]   = txPop;

  // frame bytes flow through untouched
  assign rxDataOut  = rxDataIn;
  assign rxValidOut = rxValidIn;
  assign txDataOut  = txDataIn;
  assign txValidOut = txValidIn;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    stampStrb_t laneStrb;

    ptp_stamper_ctrl #(.PTP_PORT(PTP_PORT)) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .inData  (laneData[l]),
      .inValid (laneValid[l]),
      .strb    (laneStrb)
    );

    ptp_stamper_dp #(.TIME_W(TIME_W), .DEPTH(DEPTH)) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (laneStrb),
      .timeNow  (timeNow),
      .inData   (laneData[l]),
      .pop      (lanePop[l]),
      .notEmpty (laneNe[l]),
      .outTime  (laneTime[l]),
      .outSeq   (laneSeq[l]),
      .outType  (laneType[l]),
      .overflow (laneOvf[l])
    );
  end

  assign rxNotEmpty  = laneNe[0];
  assign rxStampTime = laneTime[0];
  assign rxSeqId     = laneSeq[0];
  assign rxMsgType   = laneType[0];
  assign rxOverflow  = laneOvf[0];
  assign txNotEmpty  = laneNe[1];
  assign txStampTime = laneTime[1];
  assign txSeqId     = laneSeq[1];
  assign txMsgType   = laneType[1];
  assign txOverflow  = laneOvf[1];

endmodule

// File: tb/ptp_frame_stamper_tb.sv
module ptp_frame_stamper_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [63:0] timeNow = 64'h1000_0000_0000_0000;
  always @(posedge clk) timeNow <= timeNow + 64'd3;

  logic [7:0]  dIn   [2];
  logic        vIn   [2];
  logic        popDrv[2];
  logic [7:0]  dOut  [2];
  logic        vOut  [2];
  logic        neArr [2];
  logic        ovArr [2];
  logic [63:0] tArr  [2];
  logic [15:0] sArr  [2];
  logic [3:0]  yArr  [2];

  ptp_frame_stamper u_dut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow),
    .rxDataIn(dIn[0]), .rxValidIn(vIn[0]), .rxDataOut(dOut[0]), .rxValidOut(vOut[0]),
    .txDataIn(dIn[1]), .txValidIn(vIn[1]), .txDataOut(dOut[1]), .txValidOut(vOut[1]),
    .rxPop(popDrv[0]), .rxNotEmpty(neArr[0]), .rxStampTime(tArr[0]), .rxSeqId(sArr[0]),
    .rxMsgType(yArr[0]), .rxOverflow(ovArr[0]),
    .txPop(popDrv[1]), .txNotEmpty(neArr[1]), .txStampTime(tArr[1]), .txSeqId(sArr[1]),
    .txMsgType(yArr[1]), .txOverflow(ovArr[1])
  );

  typedef struct packed {
    logic [63:0] t;
    logic [15:0] seq;
    logic [3:0]  typ;
  } rec_t;

  rec_t expRx[$];
  rec_t expTx[$];
  int   checkCnt = 0;
  int   failCnt  = 0;
  bit   monOn[2];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops each record and compares with the driver's expectation
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (popDrv[d]) begin
        popDrv[d] = 1'b0;
      end else if (monOn[d] && neArr[d]) begin
        rec_t e;
        if ((d == 0 && expRx.size() == 0) || (d == 1 && expTx.size() == 0)) begin
          check(1'b0, "R3/R4/R7 unexpected record", {48'd0, sArr[d]}, 64'd0);
        end else begin
          e = (d == 0) ? expRx.pop_front() : expTx.pop_front();
          check(tArr[d] == e.t, "R2 stamp time", tArr[d], e.t);
          check(sArr[d] == e.seq, "R5 sequence id", {48'd0, sArr[d]}, {48'd0, e.seq});
          check(yArr[d] == e.typ, "R4 message type", {60'd0, yArr[d]}, {60'd0, e.typ});
        end
        popDrv[d] = 1'b1;
      end
    end
  end

  task automatic driveByte(input int d, input logic [7:0] b);
    @(negedge clk);
    dIn[d] = b;
    vIn[d] = 1'b1;
  endtask

  // driver: builds a frame, predicts its record, and sends it
  task automatic sendFrame(input int d, input logic [7:0] msg, input logic [15:0] seq,
                           input int corruptIdx, input int cut, input bit junk, input bit keep);
    logic [7:0] body[80];
    bit accept;
    rec_t r;
    int n;
    for (int i = 0; i < 80; i++) body[i] = 8'(i * 7 + 3);
    body[12] = 8'h08; body[13] = 8'h00; body[14] = 8'h45; body[23] = 8'h11;
    body[36] = 8'h01; body[37] = 8'h3F; body[42] = msg;  body[43] = 8'h02;
    body[72] = seq[15:8]; body[73] = seq[7:0];
    if (corruptIdx >= 0) body[corruptIdx] = body[corruptIdx] ^ 8'h01;
    accept = !junk && corruptIdx < 0 && (cut < 0 || cut > 73) && msg[3:0] <= 4'd1 && keep;
    if (junk) driveByte(d, 8'h00);
    for (int i = 0; i < 7; i++) driveByte(d, 8'h55);
    driveByte(d, 8'hD5);
    r.t = timeNow; r.seq = seq; r.typ = msg[3:0];
    if (accept) begin
      if (d == 0) expRx.push_back(r); else expTx.push_back(r);
    end
    #1;
    check(dOut[d] == dIn[d] && vOut[d] == vIn[d], "R1 pass-through",
          {55'd0, vOut[d], dOut[d]}, {55'd0, vIn[d], dIn[d]});
    n = (cut < 0) ? 80 : cut;
    for (int i = 0; i < n; i++) driveByte(d, body[i]);
    @(negedge clk);
    vIn[d] = 1'b0;
    dIn[d] = 8'h00;
    repeat (12) @(negedge clk);
  endtask

  task automatic settle(input string tag);
    repeat (24) @(negedge clk);
    check(expRx.size() == 0, tag, 64'(expRx.size()), 64'd0);
    check(expTx.size() == 0, tag, 64'(expTx.size()), 64'd0);
    check(!neArr[0] && !neArr[1], tag, {62'd0, neArr[0], neArr[1]}, 64'd0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog R1 to R11 run: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    monOn[0] = 0; monOn[1] = 0;
    popDrv[0] = 0; popDrv[1] = 0;
    dIn[0] = 0; dIn[1] = 0; vIn[0] = 0; vIn[1] = 0;
    doReset();
    // R10 reset state
    check(!neArr[0] && !neArr[1], "R10 empty after reset", {62'd0, neArr[0], neArr[1]}, 64'd0);
    check(!ovArr[0] && !ovArr[1], "R10 no overflow after reset", {62'd0, ovArr[0], ovArr[1]}, 64'd0);
    monOn[0] = 1; monOn[1] = 1;

    // R2 R4 R5 basic records on each side
    sendFrame(0, 8'h00, 16'h1234, -1, -1, 0, 1);
    sendFrame(1, 8'h01, 16'hABCD, -1, -1, 0, 1);
    sendFrame(0, 8'h11, 16'h0F0E, -1, -1, 0, 1);   // upper nibble ignored, R4
    settle("R2/R5 queue drained");

    // R4 other message types give no record
    sendFrame(0, 8'h02, 16'h2222, -1, -1, 0, 1);
    sendFrame(1, 8'h08, 16'h3333, -1, -1, 0, 1);
    settle("R4 non-event types ignored");

    // R3 each field test rejects a mismatch
    sendFrame(0, 8'h00, 16'h4001, 12, -1, 0, 1);
    sendFrame(0, 8'h00, 16'h4002, 13, -1, 0, 1);
    sendFrame(0, 8'h00, 16'h4003, 14, -1, 0, 1);
    sendFrame(1, 8'h01, 16'h4004, 23, -1, 0, 1);
    sendFrame(1, 8'h01, 16'h4005, 36, -1, 0, 1);
    sendFrame(1, 8'h01, 16'h4006, 37, -1, 0, 1);
    sendFrame(0, 8'h00, 16'h4007, 43, -1, 0, 1);
    settle("R3 mismatched fields ignored");

    // R6 truncated frames discarded, boundary at byte 73
    sendFrame(0, 8'h00, 16'h5001, -1, 30, 0, 1);
    sendFrame(0, 8'h00, 16'h5002, -1, 73, 0, 1);
    sendFrame(0, 8'h00, 16'h5003, -1, 74, 0, 1);   // byte 73 taken: kept
    sendFrame(0, 8'h01, 16'h5004, -1, -1, 0, 1);   // recovery after cut
    settle("R6 truncation handling");

    // R11 junk lead byte
    sendFrame(1, 8'h00, 16'h6001, -1, -1, 1, 1);
    settle("R11 junk-led frame ignored");

    // R7 overlapping traffic on both sides
    fork
      sendFrame(0, 8'h00, 16'h7001, -1, -1, 0, 1);
      begin
        repeat (3) @(negedge clk);
        sendFrame(1, 8'h01, 16'h7002, -1, -1, 0, 1);
      end
    join
    fork
      sendFrame(0, 8'h01, 16'h7003, 14, -1, 0, 1);
      sendFrame(1, 8'h00, 16'h7004, -1, -1, 0, 1);
    join
    settle("R7 independent lanes");

    // R9 overflow on receive side
    monOn[0] = 0;
    for (int i = 0; i < 5; i++) sendFrame(0, 8'h00, 16'h0100 + 16'(i), -1, -1, 0, i < 4);
    @(negedge clk);
    check(ovArr[0] == 1'b1, "R9 overflow set", {63'd0, ovArr[0]}, 64'd1);
    check(neArr[0] == 1'b1, "R8 queue holds records", {63'd0, neArr[0]}, 64'd1);
    check(ovArr[1] == 1'b0, "R7 transmit overflow untouched", {63'd0, ovArr[1]}, 64'd0);
    monOn[0] = 1;
    settle("R9 four oldest records kept");
    monOn[0] = 0;
    // R8 pop on empty has no effect
    @(negedge clk); popDrv[0] = 1'b1;
    @(negedge clk); popDrv[0] = 1'b0;
    @(negedge clk);
    check(neArr[0] == 1'b0, "R8 empty pop ignored", {63'd0, neArr[0]}, 64'd0);
    check(ovArr[0] == 1'b1, "R9 overflow sticky", {63'd0, ovArr[0]}, 64'd1);
    monOn[0] = 1;
    sendFrame(0, 8'h01, 16'h0200, -1, -1, 0, 1);
    settle("R8 queue usable after empty pop");
    check(ovArr[0] == 1'b1, "R9 overflow still sticky", {63'd0, ovArr[0]}, 64'd1);

    monOn[0] = 0; monOn[1] = 0;
    doReset();
    check(ovArr[0] == 1'b0, "R10 reset clears overflow", {63'd0, ovArr[0]}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule